// File: doc/BRIEF.md
# Per-Bank Row Timing Sequencer

This block sits between a memory request source and a banked dynamic-memory array. It takes one request at a time (open a row, read a column, write a column, or close the row) over a valid/ready handshake. Each request names a bank, a row and a column. The block decides whether that request may go out now. If it may, the block emits a one-cycle command strobe with the request's bank, row and column echoed beside it.

Every bank has its own row state and its own set of spacing windows, measured in clock cycles and set by parameters:

- activate-to-column delay
- activate-to-close minimum
- close-to-activate recovery
- activate-to-activate cycle

A request whose window has not yet elapsed is held off by keeping ready low. It is issued as soon as the window runs out and is never discarded. A request that makes no sense for the bank's row state is accepted at once and answered with an error pulse instead of a command. Because the windows are kept per bank, work on one bank proceeds while another bank is still waiting.

Top module: `bank_row_sequencer`

## Requirements
- R1: After reset every bank reports no open row, all command strobes and the error pulse are low, and an activate to any bank is accepted without stalling.
- R2: An accepted activate (req_cmd = 0) to a closed bank raises act_stb for exactly the next cycle. From that cycle the bank's bank_open bit is 1 and its open_row slice (bits b*ROW_W upward) holds the requested row.
- R3: A read (req_cmd = 1) or write (req_cmd = 2) to an open bank is accepted no earlier than T_RCD cycles after that bank's activate was accepted. Consecutive column commands to an open bank need no spacing.
- R4: A precharge (req_cmd = 3) to an open bank is accepted no earlier than T_RAS cycles after that bank's activate was accepted. In the cycle of its strobe the bank's bank_open bit is 0.
- R5: An activate to a bank is accepted no earlier than T_RP cycles after that bank's precharge was accepted.
- R6: Two activates accepted for the same bank are at least T_RC cycles apart.
- R7: A read, write or precharge to a bank with no open row is accepted with no stall. It pulses err_stb in the next cycle, produces no command strobe, and leaves the bank closed.
- R8: An activate to a bank that already has an open row is accepted with no stall. It pulses err_stb in the next cycle, produces no command strobe, and leaves the open row unchanged.
- R9: A request whose timing window has not elapsed sees req_ready low. It is accepted on the first cycle the window allows, which is the latest of its applicable limits, and is never dropped.
- R10: Windows are tracked per bank, so a request to one bank is not delayed by another bank's pending window.
- R11: At most one command strobe is high in any cycle. iss_bank, iss_row and iss_col hold the fields of the request that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken this cycle |
| req_cmd | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open (activate) |
| req_col | input | COL_W | Column (read/write) |
| act_stb | output | 1 | Activate issued |
| rd_stb | output | 1 | Read issued |
| wr_stb | output | 1 | Write issued |
| pre_stb | output | 1 | Precharge issued |
| err_stb | output | 1 | Request rejected for bank state |
| iss_bank | output | BANK_W | Bank of the last accepted request |
| iss_row | output | ROW_W | Row of the last accepted request |
| iss_col | output | COL_W | Column of the last accepted request |
| bank_open | output | NUM_BANKS | One bit per bank, row open |
| open_row | output | NUM_BANKS*ROW_W | Open row of each bank, packed |

## Verification
Some rules hold on every cycle, and the bound checker tests them at each edge:

- the four spacing rules, measured strobe to strobe with free-running age counters per bank
- that strobes are exclusive
- that an error pulse carries no command
- that activate and precharge strobes agree with the open-row status

Other behaviours need scenarios, and only the bench's sweep shows them:

- that a stalled request is finally issued rather than lost
- that the stall ends on exactly the cycle the latest limit allows and not later
- that rejected requests leave row state untouched
- that a second bank proceeds while the first waits

The bench sweeps every bank through the full open, access, close and reopen cycle. It compares acceptance cycle gaps against values computed from the timing parameters.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } brs_cmd_e;

    // window indices inside one bank
    localparam int WIN_RCD = 0;
    localparam int WIN_RAS = 1;
    localparam int WIN_RC  = 2;
    localparam int WIN_RP  = 3;
    localparam int NUM_WIN = 4;

endpackage

// File: rtl/brs_window_ctr.sv
module brs_window_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = (st_q.cnt == '0);

endmodule

// File: rtl/brs_bank_state.sv
module brs_bank_state #(
    parameter int ROW_W = 10,
    parameter int CNT_W = 4,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_RP  = 3,
    parameter int T_RC  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] act_row,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             act_ok,
    output logic             rw_ok,
    output logic             pre_ok
);
    import brs_pkg::*;

    // a window of length T is loaded with T-1 so that the command
    // T edges after the opener is the first one allowed
    localparam int WIN_LOAD [NUM_WIN] = '{T_RCD - 1, T_RAS - 1, T_RC - 1, T_RP - 1};

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [NUM_WIN-1:0] win_load;
    logic [NUM_WIN-1:0] win_done;

    always_comb begin
        win_load          = '0;
        win_load[WIN_RCD] = act_go;
        win_load[WIN_RAS] = act_go;
        win_load[WIN_RC]  = act_go;
        win_load[WIN_RP]  = pre_go;
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        brs_window_ctr #(
            .CNT_W (CNT_W)
        ) ctr_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (win_load[w]),
            .load_val (CNT_W'(WIN_LOAD[w])),
            .expired  (win_done[w])
        );
    end

    always_comb begin
        st_d = st_q;
        if (act_go) begin
            st_d.open = 1'b1;
            st_d.row  = act_row;
        end else if (pre_go) begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = st_q.open;
    assign row_o  = st_q.row;
    assign act_ok = !st_q.open && win_done[WIN_RP] && win_done[WIN_RC];
    assign rw_ok  = st_q.open && win_done[WIN_RCD];
    assign pre_ok = st_q.open && win_done[WIN_RAS];

endmodule

// File: rtl/brs_req_gate.sv
module brs_req_gate #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic                 req_valid,
    input  logic [1:0]           req_cmd,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [NUM_BANKS-1:0] open_vec,
    input  logic [NUM_BANKS-1:0] act_ok_vec,
    input  logic [NUM_BANKS-1:0] rw_ok_vec,
    input  logic [NUM_BANKS-1:0] pre_ok_vec,
    output logic                 ready,
    output logic                 reject,
    output logic [NUM_BANKS-1:0] act_go,
    output logic [NUM_BANKS-1:0] pre_go,
    output logic                 rd_go,
    output logic                 wr_go
);
    import brs_pkg::*;

    brs_cmd_e cmd;
    logic     in_range;
    logic     sel_open;
    logic     sel_act_ok;
    logic     sel_rw_ok;
    logic     sel_pre_ok;
    logic     state_err;
    logic     time_ok;
    logic     accept;
    logic     issue;

    assign cmd = brs_cmd_e'(req_cmd);

    always_comb begin
        in_range   = 1'b0;
        sel_open   = 1'b0;
        sel_act_ok = 1'b0;
        sel_rw_ok  = 1'b0;
        sel_pre_ok = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (req_bank == BANK_W'(b)) begin
                in_range   = 1'b1;
                sel_open   = open_vec[b];
                sel_act_ok = act_ok_vec[b];
                sel_rw_ok  = rw_ok_vec[b];
                sel_pre_ok = pre_ok_vec[b];
            end
        end

        unique case (cmd)
            CMD_ACT: begin
                state_err = !in_range || sel_open;
                time_ok   = sel_act_ok;
            end
            CMD_RD, CMD_WR: begin
                state_err = !sel_open;
                time_ok   = sel_rw_ok;
            end
            default: begin
                state_err = !sel_open;
                time_ok   = sel_pre_ok;
            end
        endcase

        ready  = state_err || time_ok;
        accept = req_valid && ready;
        reject = accept && state_err;
        issue  = accept && !state_err;

        act_go = '0;
        pre_go = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (req_bank == BANK_W'(b)) begin
                act_go[b] = issue && (cmd == CMD_ACT);
                pre_go[b] = issue && (cmd == CMD_PRE);
            end
        end
        rd_go = issue && (cmd == CMD_RD);
        wr_go = issue && (cmd == CMD_WR);
    end

endmodule

// File: rtl/bank_row_sequencer.sv
module bank_row_sequencer #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 10,
    parameter int COL_W     = 7,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 3,
    parameter int T_RC      = 11,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [1:0]                 req_cmd,
    input  logic [BANK_W-1:0]          req_bank,
    input  logic [ROW_W-1:0]           req_row,
    input  logic [COL_W-1:0]           req_col,
    output logic                       act_stb,
    output logic                       rd_stb,
    output logic                       wr_stb,
    output logic                       pre_stb,
    output logic                       err_stb,
    output logic [BANK_W-1:0]          iss_bank,
    output logic [ROW_W-1:0]           iss_row,
    output logic [COL_W-1:0]           iss_col,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_row
);

    localparam int T_MAX_A = (T_RCD > T_RAS) ? T_RCD : T_RAS;
    localparam int T_MAX_B = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    typedef struct packed {
        logic              act;
        logic              rd;
        logic              wr;
        logic              pre;
        logic              err;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } out_st_t;

    out_st_t out_d, out_q;

    logic [NUM_BANKS-1:0] open_vec;
    logic [NUM_BANKS-1:0] act_ok_vec;
    logic [NUM_BANKS-1:0] rw_ok_vec;
    logic [NUM_BANKS-1:0] pre_ok_vec;
    logic [NUM_BANKS-1:0] act_go;
    logic [NUM_BANKS-1:0] pre_go;
    logic                 rd_go;
    logic                 wr_go;
    logic                 reject;
    logic                 ready;

    brs_req_gate #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) gate_i (
        .req_valid  (req_valid),
        .req_cmd    (req_cmd),
        .req_bank   (req_bank),
        .open_vec   (open_vec),
        .act_ok_vec (act_ok_vec),
        .rw_ok_vec  (rw_ok_vec),
        .pre_ok_vec (pre_ok_vec),
        .ready      (ready),
        .reject     (reject),
        .act_go     (act_go),
        .pre_go     (pre_go),
        .rd_go      (rd_go),
        .wr_go      (wr_go)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        brs_bank_state #(
            .ROW_W (ROW_W),
            .CNT_W (CNT_W),
            .T_RCD (T_RCD),
            .T_RAS (T_RAS),
            .T_RP  (T_RP),
            .T_RC  (T_RC)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_go  (act_go[b]),
            .pre_go  (pre_go[b]),
            .act_row (req_row),
            .open_o  (open_vec[b]),
            .row_o   (open_row[b*ROW_W +: ROW_W]),
            .act_ok  (act_ok_vec[b]),
            .rw_ok   (rw_ok_vec[b]),
            .pre_ok  (pre_ok_vec[b])
        );
    end

    always_comb begin
        out_d     = out_q;
        out_d.act = |act_go;
        out_d.rd  = rd_go;
        out_d.wr  = wr_go;
        out_d.pre = |pre_go;
        out_d.err = reject;
        if (req_valid && ready) begin
            out_d.bank = req_bank;
            out_d.row  = req_row;
            out_d.col  = req_col;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign req_ready = ready;
    assign act_stb   = out_q.act;
    assign rd_stb    = out_q.rd;
    assign wr_stb    = out_q.wr;
    assign pre_stb   = out_q.pre;
    assign err_stb   = out_q.err;
    assign iss_bank  = out_q.bank;
    assign iss_row   = out_q.row;
    assign iss_col   = out_q.col;
    assign bank_open = open_vec;

endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 10,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 3,
    parameter int T_RC      = 11,
    parameter int BANK_W    = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       act_stb,
    input logic                       rd_stb,
    input logic                       wr_stb,
    input logic                       pre_stb,
    input logic                       err_stb,
    input logic [BANK_W-1:0]          iss_bank,
    input logic [ROW_W-1:0]           iss_row,
    input logic [NUM_BANKS-1:0]       bank_open,
    input logic [NUM_BANKS*ROW_W-1:0] open_row
);

    localparam int AGE_W   = $clog2(T_RC + T_RAS + T_RP + T_RCD + 2) + 1;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [AGE_W-1:0] act_age [NUM_BANKS];
    logic [AGE_W-1:0] pre_age [NUM_BANKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                act_age[b] <= AGE_MAX;
                pre_age[b] <= AGE_MAX;
            end
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (act_stb && iss_bank == BANK_W'(b)) begin
                    act_age[b] <= AGE_W'(1);
                end else if (act_age[b] != AGE_MAX) begin
                    act_age[b] <= act_age[b] + AGE_W'(1);
                end
                if (pre_stb && iss_bank == BANK_W'(b)) begin
                    pre_age[b] <= AGE_W'(1);
                end else if (pre_age[b] != AGE_MAX) begin
                    pre_age[b] <= pre_age[b] + AGE_W'(1);
                end
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_stb, rd_stb, wr_stb, pre_stb})); // R11

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err_stb |-> !(act_stb || rd_stb || wr_stb || pre_stb)); // R7

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        act_stb |-> (bank_open[iss_bank] && open_row[iss_bank*ROW_W +: ROW_W] == iss_row)); // R2

    AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> bank_open[iss_bank]); // R3

    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        pre_stb |-> !bank_open[iss_bank]); // R4

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            ((rd_stb || wr_stb) && iss_bank == BANK_W'(b)) |-> act_age[b] >= AGE_W'(T_RCD)); // R3

        AST_RAS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_stb && iss_bank == BANK_W'(b)) |-> act_age[b] >= AGE_W'(T_RAS)); // R4

        AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (act_stb && iss_bank == BANK_W'(b)) |-> pre_age[b] >= AGE_W'(T_RP)); // R5

        AST_RC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (act_stb && iss_bank == BANK_W'(b)) |-> act_age[b] >= AGE_W'(T_RC)); // R6
    end

endmodule

bind bank_row_sequencer brs_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .T_RCD     (T_RCD),
    .T_RAS     (T_RAS),
    .T_RP      (T_RP),
    .T_RC      (T_RC),
    .BANK_W    (BANK_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_stb   (act_stb),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .pre_stb   (pre_stb),
    .err_stb   (err_stb),
    .iss_bank  (iss_bank),
    .iss_row   (iss_row),
    .bank_open (bank_open),
    .open_row  (open_row)
);

// File: tb/bank_row_sequencer_tb_top.sv
`timescale 1ns/1ps
module bank_row_sequencer_tb_top;
    import brs_pkg::*;

    localparam int NB    = 4;
    localparam int RW    = 10;
    localparam int CW    = 7;
    localparam int BW    = 2;
    localparam int P_RCD = 3;
    localparam int P_RAS = 6;
    localparam int P_RP  = 3;
    localparam int P_RC  = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_cmd = '0;
    logic [BW-1:0]    req_bank = '0;
    logic [RW-1:0]    req_row = '0;
    logic [CW-1:0]    req_col = '0;
    logic             act_stb, rd_stb, wr_stb, pre_stb, err_stb;
    logic [BW-1:0]    iss_bank;
    logic [RW-1:0]    iss_row;
    logic [CW-1:0]    iss_col;
    logic [NB-1:0]    bank_open;
    logic [NB*RW-1:0] open_row;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bank_row_sequencer #(
        .NUM_BANKS (NB), .ROW_W (RW), .COL_W (CW),
        .T_RCD (P_RCD), .T_RAS (P_RAS), .T_RP (P_RP), .T_RC (P_RC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_cmd (req_cmd), .req_bank (req_bank), .req_row (req_row), .req_col (req_col),
        .act_stb (act_stb), .rd_stb (rd_stb), .wr_stb (wr_stb), .pre_stb (pre_stb),
        .err_stb (err_stb), .iss_bank (iss_bank), .iss_row (iss_row), .iss_col (iss_col),
        .bank_open (bank_open), .open_row (open_row)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // drive a request, wait for ready, return the accept edge index and stall count
    task automatic send(input brs_cmd_e c, input int b, input int row, input int col,
                        output int acc, output int waits);
        req_cmd   = c;
        req_bank  = BW'(b);
        req_row   = RW'(row);
        req_col   = CW'(col);
        req_valid = 1'b1;
        waits     = 0;
        #1;
        while (!req_ready && waits < 1000) begin
            @(negedge clk);
            waits++;
        end
        if (waits >= 1000) check(1'b0, "R9 request never accepted", waits, 0);
        @(posedge clk);
        @(negedge clk);
        acc       = cyc;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R9 watchdog expired", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int a_act, a_rd, a_wr, a_pre, a_x, a_act2, a_pre2, a_act3, w;
        int row, col, exp_gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(bank_open == '0, "R1 banks closed after reset", bank_open, 0);
        check({act_stb, rd_stb, wr_stb, pre_stb, err_stb} == '0, "R1 strobes low after reset",
              {act_stb, rd_stb, wr_stb, pre_stb, err_stb}, 0);

        for (int b = 0; b < NB; b++) begin
            row = (b * 37 + 5) % (1 << RW);
            col = (b * 11 + 3) % (1 << CW);

            send(CMD_ACT, b, row, 0, a_act, w);
            check(w == 0, "R1 first activate not stalled", w, 0);
            check(act_stb == 1'b1, "R2 act strobe", act_stb, 1);
            check(bank_open[b] == 1'b1, "R2 bank marked open", bank_open[b], 1);
            check(open_row[b*RW +: RW] == RW'(row), "R2 open row value", open_row[b*RW +: RW], row);
            check(iss_bank == BW'(b), "R11 issued bank", iss_bank, b);

            send(CMD_RD, b, 0, col, a_rd, w);
            check(a_rd - a_act == P_RCD, "R3 read spacing after activate", a_rd - a_act, P_RCD);
            check(rd_stb && !wr_stb, "R3 read strobe", rd_stb, 1);
            check(iss_col == CW'(col), "R11 issued column", iss_col, col);

            send(CMD_WR, b, 0, col + 1, a_wr, w);
            check(a_wr - a_rd == 1, "R3 back-to-back write", a_wr - a_rd, 1);
            check(wr_stb == 1'b1, "R3 write strobe", wr_stb, 1);

            send(CMD_PRE, b, 0, 0, a_pre, w);
            check(a_pre - a_act == P_RAS, "R4 precharge spacing", a_pre - a_act, P_RAS);
            check(pre_stb && !bank_open[b], "R4 precharge closes bank", bank_open[b], 0);

            send(CMD_RD, b, 0, col, a_x, w);
            check(w == 0, "R7 error read not stalled", w, 0);
            check(err_stb && !rd_stb, "R7 error pulse without read", {err_stb, rd_stb}, 2);
            check(bank_open[b] == 1'b0, "R7 bank stays closed", bank_open[b], 0);

            send(CMD_ACT, b, row + 1, 0, a_act2, w);
            exp_gap = (P_RC > (a_pre - a_act) + P_RP) ? P_RC : (a_pre - a_act) + P_RP;
            check(a_act2 - a_act == exp_gap, "R6 R9 activate-to-activate stall", a_act2 - a_act, exp_gap);

            send(CMD_ACT, b, row + 7, 0, a_x, w);
            check(err_stb && !act_stb, "R8 activate to open bank rejected", {err_stb, act_stb}, 2);
            check(open_row[b*RW +: RW] == RW'(row + 1), "R8 open row unchanged",
                  open_row[b*RW +: RW], row + 1);

            repeat (P_RC + 2) @(negedge clk);
            send(CMD_PRE, b, 0, 0, a_pre2, w);
            check(w == 0, "R4 late precharge not stalled", w, 0);
            send(CMD_ACT, b, row + 2, 0, a_act3, w);
            check(a_act3 - a_pre2 == P_RP, "R5 precharge-to-activate spacing", a_act3 - a_pre2, P_RP);

            send(CMD_PRE, b, 0, 0, a_pre, w);
            check(a_pre - a_act3 == P_RAS, "R4 close after reopen", a_pre - a_act3, P_RAS);
        end

        // R10 interleaving across two banks
        repeat (P_RC + P_RP) @(negedge clk);
        send(CMD_ACT, 0, 17, 0, a_act, w);
        send(CMD_ACT, 1, 19, 0, a_act2, w);
        check(a_act2 - a_act == 1, "R10 second bank activates at once", a_act2 - a_act, 1);
        send(CMD_RD, 0, 0, 2, a_rd, w);
        check(a_rd - a_act == P_RCD, "R10 bank0 read spacing", a_rd - a_act, P_RCD);
        send(CMD_WR, 1, 0, 4, a_wr, w);
        check(a_wr - a_act2 == P_RCD, "R10 bank1 write spacing", a_wr - a_act2, P_RCD);
        check(wr_stb && iss_bank == 2'd1, "R11 write on bank1", iss_bank, 1);
        check(bank_open == 4'b0011, "R10 two banks open", bank_open, 3);
        send(CMD_PRE, 0, 0, 0, a_pre, w);
        send(CMD_PRE, 1, 0, 0, a_pre2, w);
        check(a_pre2 - a_pre == 1, "R10 bank1 close right after bank0", a_pre2 - a_pre, 1);
        check(bank_open == '0, "R4 all banks closed", bank_open, 0);

        @(negedge clk);
        summary();
        $finish;
    end

endmodule